// File: doc/BRIEF.md
# Piecewise Linear Thermal Code Converter

This block turns a raw 12-bit thermal sensor code into a signed temperature in millidegrees Celsius. The response of the sensor is modelled by two straight lines. A set of three reference-voltage calibration words and three code calibration words, one set for each sensor, determines both lines. A scale constant sets the slope. Each segment has its own integer offset in whole degrees. The middle code calibration word is the breakpoint: a code below it falls on the lower segment, and any other code falls on the upper segment.

One conversion starts with a single-cycle start strobe. The block captures the code and all constants at that edge. It then forms the slope numerator and denominator of the selected segment and runs a bit-serial restoring division. The division produces the deci-degree value, rounded to the nearest integer with halves moved away from zero. The block scales this value to millidegrees and adds the offset. It presents the result together with a one-cycle done pulse. The division uses one tenth of the denominator, which keeps the deci-degree precision without enlarging the dividend. A start strobe that arrives while a conversion is in flight is dropped.

Top module: `thermo_code_conv`

## Requirements
- R1: After reset, done is 0 and tempMilli is 0.
- R2: When code < calC1 (unsigned), the block uses the lower segment with reference code calC2 and offset offLow. In every other case, including code == calC1, it uses the upper segment with reference code calC0 and offset offHigh.
- R3: The segment coefficients are computed as signed integers. Lower: a = scale*(calP2-calP1), b = (calP2-calP0)*(calC2-calC1). Upper: a = scale*(calP0-calP1), b = (calP0-calP2)*(calC1-calC0).
- R4: The divisor is b/10 with the fraction truncated toward zero, for either sign of b. For example, 25 gives 2 and -25 gives -2.
- R5: deci = a*(ref-code) divided by the divisor and rounded to the nearest integer. An exact half moves away from zero, so 0.5 gives 1 and -0.5 gives -1. The sign follows the signs of the dividend and the divisor.
- R6: tempMilli = deci*100 + offset*1000, as a 32-bit two's complement value.
- R7: done is high for exactly one cycle. It rises on the 50th rising edge after the edge that accepted start, which is the data width (48) plus 2.
- R8: A start that is high while a conversion is in flight is ignored. It produces no extra done pulse and does not change the result of the running conversion.
- R9: tempMilli holds its value in every cycle in which done is low.
- R10: When the divisor is 0, deci is 0, so tempMilli equals offset*1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| calP0 | input | 12 | First reference-voltage calibration word |
| calP1 | input | 12 | Second reference-voltage calibration word |
| calP2 | input | 12 | Third reference-voltage calibration word |
| calC0 | input | 12 | Code calibration, hot end (upper reference) |
| calC1 | input | 12 | Code calibration, breakpoint |
| calC2 | input | 12 | Code calibration, cold end (lower reference) |
| scale | input | 16 | Slope scale constant, unsigned |
| offLow | input | 8 | Lower segment offset in degrees, signed |
| offHigh | input | 8 | Upper segment offset in degrees, signed |
| code | input | 12 | Raw sensor code |
| start | input | 1 | Start strobe, sampled while idle |
| tempMilli | output | 32 | Temperature in millidegrees Celsius, signed |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The main function runs on the default calibration with codes at the three calibration points and at both extremes, and on a second calibration set with a different scale and upper offset. The codes at the calibration points separate the two sides of the breakpoint compare, including equality, and they pin down the offset-only result at each reference code. Contrived small calibrations produce dividends that fall exactly on a half, and denominators of 25 and -25. These separate rounding away from zero from rounding toward zero or toward minus infinity, and they separate truncation of b/10 from floor or rounding. A calibration with equal outer reference words makes the divisor zero. A second start strobe issued during a conversion shows whether a busy start is dropped or restarts the datapath.

// File: rtl/thermo_conv_pkg.sv
package thermo_conv_pkg;

  typedef struct packed {
    logic load;
    logic prep;
    logic step;
    logic finish;
  } conv_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_DIV,
    ST_FIN
  } conv_state_t;

endpackage

// File: rtl/thermo_conv_ctrl.sv
module thermo_conv_ctrl
  import thermo_conv_pkg::*;
#(
  parameter int DIV_STEPS = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output conv_strobe_t strobe
);

  localparam int CNT_W = (DIV_STEPS > 1) ? $clog2(DIV_STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DIV_STEPS - 1);

  conv_state_t state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobe.load   = start && (state == ST_IDLE);
    strobe.prep   = (state == ST_PREP);
    strobe.step   = (state == ST_DIV);
    strobe.finish = (state == ST_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_PREP;
        ST_PREP: begin
          state   <= ST_DIV;
          stepCnt <= '0;
        end
        ST_DIV: begin
          if (stepCnt == LAST_STEP) begin
            state   <= ST_FIN;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: the step counter never runs past the division length
  a_r7_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DIV) |-> (stepCnt <= LAST_STEP));

  // R8: a busy start never produces a load strobe on the following cycle
  a_r8_busy_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load) |=> (!strobe.load && strobe.prep));

endmodule

// File: rtl/thermo_conv_dp.sv
module thermo_conv_dp
  import thermo_conv_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int SCALE_W = 16,
  parameter int OFF_W   = 8,
  parameter int ACC_W   = 48,
  parameter int OUT_W   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  conv_strobe_t            strobe,
  input  logic [CODE_W-1:0]       calP0,
  input  logic [CODE_W-1:0]       calP1,
  input  logic [CODE_W-1:0]       calP2,
  input  logic [CODE_W-1:0]       calC0,
  input  logic [CODE_W-1:0]       calC1,
  input  logic [CODE_W-1:0]       calC2,
  input  logic [SCALE_W-1:0]      scale,
  input  logic signed [OFF_W-1:0] offLow,
  input  logic signed [OFF_W-1:0] offHigh,
  input  logic [CODE_W-1:0]       code,
  output logic signed [OUT_W-1:0] tempMilli,
  output logic                    done
);

  localparam int CPAD = ACC_W - CODE_W;
  localparam int SPAD = ACC_W - SCALE_W;
  localparam int OPAD = ACC_W - OFF_W;
  localparam logic signed [ACC_W-1:0] TEN      = ACC_W'(10);
  localparam logic signed [ACC_W-1:0] HUNDRED  = ACC_W'(100);
  localparam logic signed [ACC_W-1:0] THOUSAND = ACC_W'(1000);

  function automatic logic signed [ACC_W-1:0] zx(input logic [CODE_W-1:0] v);
    return $signed({{CPAD{1'b0}}, v});
  endfunction

  // load stage: segment selection and coefficients
  logic signed [ACC_W-1:0] sP0, sP1, sP2, sC0, sC1, sC2, sScale;
  logic signed [ACC_W-1:0] aLow, bLow, aHigh, bHigh;
  logic                    lowSeg;

  always_comb begin
    sP0    = zx(calP0);
    sP1    = zx(calP1);
    sP2    = zx(calP2);
    sC0    = zx(calC0);
    sC1    = zx(calC1);
    sC2    = zx(calC2);
    sScale = $signed({{SPAD{1'b0}}, scale});
    lowSeg = (code < calC1);
    aLow   = sScale * (sP2 - sP1);
    bLow   = (sP2 - sP0) * (sC2 - sC1);
    aHigh  = sScale * (sP0 - sP1);
    bHigh  = (sP0 - sP2) * (sC1 - sC0);
  end

  logic signed [ACC_W-1:0] coefA, coefB;
  logic [CODE_W-1:0]       refReg, codeReg;
  logic signed [OFF_W-1:0] offReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coefA   <= '0;
      coefB   <= '0;
      refReg  <= '0;
      codeReg <= '0;
      offReg  <= '0;
    end else if (strobe.load) begin
      coefA   <= lowSeg ? aLow : aHigh;
      coefB   <= lowSeg ? bLow : bHigh;
      refReg  <= lowSeg ? calC2 : calC0;
      codeReg <= code;
      offReg  <= lowSeg ? offLow : offHigh;
    end
  end

  // prep stage: dividend, truncated divisor, magnitudes and sign
  logic signed [ACC_W-1:0] numer, denom;
  logic [ACC_W-1:0]        numMag, denMag;

  always_comb begin
    numer  = coefA * (zx(refReg) - zx(codeReg));
    denom  = coefB / TEN;
    numMag = numer[ACC_W-1] ? ACC_W'(-numer) : ACC_W'(numer);
    denMag = denom[ACC_W-1] ? ACC_W'(-denom) : ACC_W'(denom);
  end

  // division stage: restoring, one quotient bit per step
  logic [ACC_W-1:0] quoReg, divMag;
  logic [ACC_W:0]   remReg, remShift, remTrial;
  logic             negReg, zeroReg;

  always_comb begin
    remShift = {remReg[ACC_W-1:0], quoReg[ACC_W-1]};
    remTrial = remShift - {1'b0, divMag};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quoReg  <= '0;
      remReg  <= '0;
      divMag  <= '0;
      negReg  <= 1'b0;
      zeroReg <= 1'b0;
    end else if (strobe.prep) begin
      quoReg  <= numMag;
      remReg  <= '0;
      divMag  <= denMag;
      negReg  <= numer[ACC_W-1] ^ denom[ACC_W-1];
      zeroReg <= (denom == '0);
    end else if (strobe.step) begin
      if (remShift >= {1'b0, divMag}) begin
        remReg <= remTrial;
        quoReg <= {quoReg[ACC_W-2:0], 1'b1};
      end else begin
        remReg <= remShift;
        quoReg <= {quoReg[ACC_W-2:0], 1'b0};
      end
    end
  end

  // finish stage: round half away from zero, apply sign, scale and offset
  logic                    roundUp;
  logic [ACC_W-1:0]        roundMag;
  logic signed [ACC_W-1:0] deci, offExt, resultFull;

  always_comb begin
    roundUp    = ({remReg, 1'b0} >= {2'b00, divMag});
    roundMag   = quoReg + {{(ACC_W-1){1'b0}}, roundUp};
    if (zeroReg)     deci = '0;
    else if (negReg) deci = -$signed(roundMag);
    else             deci = $signed(roundMag);
    offExt     = $signed({{OPAD{offReg[OFF_W-1]}}, offReg});
    resultFull = deci * HUNDRED + offExt * THOUSAND;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tempMilli <= '0;
      done      <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.finish) tempMilli <= resultFull[OUT_W-1:0];
    end
  end

  // R5: the partial remainder stays below the divisor during division
  a_r5_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.step && divMag != '0) |=> (remReg < {1'b0, divMag}));

  // R8: captured operands do not move while a conversion is in flight
  a_r8_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.prep || strobe.step) |=> ($stable(codeReg) && $stable(offReg) && $stable(refReg)));

  // R10: a zero divisor leaves only the offset in the result
  a_r10_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.finish && zeroReg) |=> (tempMilli == $signed(OUT_W'(offExt * THOUSAND))));

endmodule

// File: rtl/thermo_code_conv.sv
module thermo_code_conv
  import thermo_conv_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int SCALE_W = 16,
  parameter int OFF_W   = 8,
  parameter int ACC_W   = 48,
  parameter int OUT_W   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CODE_W-1:0]       calP0,
  input  logic [CODE_W-1:0]       calP1,
  input  logic [CODE_W-1:0]       calP2,
  input  logic [CODE_W-1:0]       calC0,
  input  logic [CODE_W-1:0]       calC1,
  input  logic [CODE_W-1:0]       calC2,
  input  logic [SCALE_W-1:0]      scale,
  input  logic signed [OFF_W-1:0] offLow,
  input  logic signed [OFF_W-1:0] offHigh,
  input  logic [CODE_W-1:0]       code,
  input  logic                    start,
  output logic signed [OUT_W-1:0] tempMilli,
  output logic                    done
);

  conv_strobe_t strobe;

  thermo_conv_ctrl #(.DIV_STEPS(ACC_W)) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .strobe (strobe)
  );

  thermo_conv_dp #(
    .CODE_W (CODE_W),
    .SCALE_W(SCALE_W),
    .OFF_W  (OFF_W),
    .ACC_W  (ACC_W),
    .OUT_W  (OUT_W)
  ) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .calP0    (calP0),
    .calP1    (calP1),
    .calP2    (calP2),
    .calC0    (calC0),
    .calC1    (calC1),
    .calC2    (calC2),
    .scale    (scale),
    .offLow   (offLow),
    .offHigh  (offHigh),
    .code     (code),
    .tempMilli(tempMilli),
    .done     (done)
  );

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the result only moves together with done
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(tempMilli));

endmodule

// File: tb/test_thermo_code_conv.sv
module test_thermo_code_conv;

  localparam int LATENCY = 50;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [11:0]       calP0 = '0, calP1 = '0, calP2 = '0;
  logic [11:0]       calC0 = '0, calC1 = '0, calC2 = '0;
  logic [15:0]       scale = '0;
  logic signed [7:0] offLow = '0, offHigh = '0;
  logic [11:0]       code = '0;
  logic              start = 1'b0;
  logic signed [31:0] tempMilli;
  logic              done;

  thermo_code_conv i_thermo_code_conv (
    .clk(clk), .rst_n(rst_n),
    .calP0(calP0), .calP1(calP1), .calP2(calP2),
    .calC0(calC0), .calC1(calC1), .calC2(calC2),
    .scale(scale), .offLow(offLow), .offHigh(offHigh),
    .code(code), .start(start),
    .tempMilli(tempMilli), .done(done)
  );

  always #2 clk = ~clk;

  typedef struct {
    longint expVal;
    longint startCyc;
    string  tag;
  } item_t;

  item_t  expQ[$];
  int     nChecks = 0;
  int     nFails = 0;
  longint cycCnt = 0;
  longint prevResult = 0;
  longint lastSeen = 0;
  bit     finished = 0;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint calcExp(longint p0, longint p1, longint p2,
                                     longint c0, longint c1, longint c2,
                                     longint sc, longint oL, longint oH, longint cd);
    longint a, b, r, o, n, d, q, rm, an, ad;
    if (cd < c1) begin
      a = sc * (p2 - p1); b = (p2 - p0) * (c2 - c1); r = c2; o = oL;
    end else begin
      a = sc * (p0 - p1); b = (p0 - p2) * (c1 - c0); r = c0; o = oH;
    end
    n = a * (r - cd);
    d = b / 10;
    if (d == 0) q = 0;
    else begin
      an = (n < 0) ? -n : n;
      ad = (d < 0) ? -d : d;
      q  = an / ad;
      rm = an % ad;
      if (2 * rm >= ad) q = q + 1;
      if ((n < 0) != (d < 0)) q = -q;
    end
    return q * 100 + o * 1000;
  endfunction

  // monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(longint'(tempMilli) == it.expVal, it.tag, longint'(tempMilli), it.expVal);
          check(cycCnt - it.startCyc == LATENCY, "R7 latency", cycCnt - it.startCyc, LATENCY);
          check(lastSeen == prevResult, "R9 hold before done", lastSeen, prevResult);
          prevResult = longint'(tempMilli);
        end
      end
      lastSeen = longint'(tempMilli);
    end
  end

  task automatic setCal(input int p0, input int p1, input int p2,
                        input int c0, input int c1, input int c2,
                        input int sc, input int oL, input int oH);
    calP0 = 12'(p0); calP1 = 12'(p1); calP2 = 12'(p2);
    calC0 = 12'(c0); calC1 = 12'(c1); calC2 = 12'(c2);
    scale = 16'(sc); offLow = 8'(oL); offHigh = 8'(oH);
  endtask

  task automatic convert(input int cd, input string tag, input bit poke);
    item_t it;
    @(negedge clk);
    code  = 12'(cd);
    start = 1'b1;
    it.expVal = calcExp(calP0, calP1, calP2, calC0, calC1, calC2,
                        scale, offLow, offHigh, cd);
    it.startCyc = cycCnt + 1;
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      code  = 12'(cd) ^ 12'h0F0;
      offHigh = offHigh + 8'sd3;
      offLow  = offLow + 8'sd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (expQ.size() == 0);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 reset done", done, 0);
    check(tempMilli == 0, "R1 reset result", tempMilli, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // default calibration, typical sensor
    setCal(2631, 1509, 435, 3397, 2800, 2221, 167, -41, 126);
    convert(2800, "R2 code equal breakpoint uses upper", 0);
    convert(2799, "R2 code below breakpoint uses lower", 0);
    convert(2221, "R6 lower reference gives offset only", 0);
    convert(3397, "R6 upper reference gives offset only", 0);
    convert(0,    "R3 lowest code", 0);
    convert(4095, "R3 highest code", 0);
    convert(2500, "R5 mid lower segment", 0);
    convert(3100, "R5 mid upper segment", 0);

    // second sensor set, other scale and upper offset
    setCal(2631, 1509, 435, 3393, 2795, 2216, 157, -41, 116);
    convert(2600, "R3 second set lower", 0);
    convert(3000, "R3 second set upper", 0);

    // exact positive half rounds up: expect 1 deci
    setCal(30, 31, 10, 99, 100, 50, 1, 0, 2);
    convert(100, "R5 positive half away from zero", 0);
    // exact negative half rounds down: expect -1 deci
    setCal(30, 29, 10, 101, 100, 50, 1, 0, 2);
    convert(100, "R5 negative half away from zero", 0);

    // divisor truncation: b=25 and b=-25 both give magnitude 2
    setCal(35, 36, 10, 99, 100, 50, 1, 0, -3);
    convert(103, "R4 positive b truncation", 0);
    setCal(10, 9, 35, 99, 100, 50, 1, 0, -3);
    convert(103, "R4 negative b truncation", 0);

    // zero divisor
    setCal(500, 300, 500, 3000, 2000, 1000, 167, -41, 126);
    convert(2500, "R10 zero divisor upper", 0);
    convert(1500, "R10 zero divisor lower", 0);

    // busy start ignored
    setCal(2631, 1509, 435, 3397, 2800, 2221, 167, -41, 126);
    convert(2650, "R8 busy start ignored", 1);
    repeat (70) @(negedge clk);
    check(expQ.size() == 0, "R8 no pending after busy start", expQ.size(), 0);
    convert(3300, "R8 accepted after busy case", 0);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule